// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block owns the refresh strobes of an asynchronous DRAM that has 512 rows. After reset it keeps every strobe inactive for a start-up delay. It then runs a burst of initialization cycles. From that point it builds up refresh debt at a fixed average rate and pays the debt back one cycle at a time. Every refresh uses the CAS-before-RAS ordering, so the memory advances its own row counter and the block drives no address. All timing minimums are given in nanoseconds. At elaboration they are turned into system-clock counts by rounding up.

The block shares the strobes with an access arbiter through a request/grant handshake. When the block has debt, it asks for the strobes with `rfsh_req_o`. The arbiter answers with a one-cycle `rfsh_gnt_i` once it has released RAS (`acc_busy_i` low). The block runs the cycle and then pulses `rfsh_done_o`. A grant can be postponed, for example while a page burst is running, because the block counts owed refreshes up to a limit. When that limit is reached, `rfsh_urgent_o` tells the arbiter to end its burst. If `lp_req_i` is high when a grant is taken, the cycle becomes a self-refresh entry. The strobes are then held low until the request is withdrawn and a minimum residency has passed, and the exit is followed by a long precharge.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and for STARTUP_CYC clocks after it is released, RAS, UCAS and LCAS stay high and `init_done_o` and `rfsh_req_o` stay low.
- R2: After the start-up delay, exactly INIT_CYCLES CAS-before-RAS cycles follow back to back, with no grant needed. `init_done_o` rises in the clock after the last precharge ends.
- R3: In every refresh cycle, UCAS and LCAS fall together CSR_CYC clocks before RAS falls.
- R4: In a normal refresh, both CAS strobes stay low for CHR_CYC clocks after RAS falls, and RAS stays low for RAS_CYC clocks in total.
- R5: Each time RAS rises, it stays high for at least RP_CYC clocks.
- R6: Once initialization is done, the owed count goes up by one every REFI_CYC clocks, saturating at OWED_MAX. `rfsh_req_o` is high while the block is idle and the count is nonzero. `rfsh_urgent_o` is high while the count equals OWED_MAX.
- R7: A grant is acted on only while the block is idle and `acc_busy_i` is low. A grant while `acc_busy_i` is high leaves all strobes high.
- R8: `rfsh_done_o` is high for exactly one clock. That clock follows the last precharge clock of a granted cycle.
- R9: A grant taken with `lp_req_i` high performs the CAS-before-RAS entry and then holds RAS and both CAS strobes low. The hold lasts for at least SELF_CYC clocks and for as long as `lp_req_i` stays high.
- R10: On self-refresh exit, RAS and both CAS strobes rise together and stay high for RPS_CYC clocks, and then `rfsh_done_o` pulses. The owed count is zero after a self-refresh entry.
- R11: If a refresh interval expires in the same clock in which a grant retires one owed refresh, the owed count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_busy_i | input | 1 | The arbiter holds RAS for an access |
| rfsh_gnt_i | input | 1 | One-clock grant of the strobes to this block |
| lp_req_i | input | 1 | Low-power request; a grant taken while high enters self-refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| rfsh_req_o | output | 1 | Block is idle and wants the strobes |
| rfsh_urgent_o | output | 1 | Owed count is saturated |
| rfsh_done_o | output | 1 | One-clock pulse when a granted cycle has finished |
| init_done_o | output | 1 | Initialization is done; normal accesses may start |

## Verification
Two events can fall in the same clock: a refresh interval expiring and a grant retiring one unit of debt. The bench reads the interval position from its own model. It then times a grant so that the DUT samples it on the exact clock where the interval wraps. After that refresh, the owed count must be unchanged, which shows up as `rfsh_req_o` staying high and matching the model clock by clock. A second overlap is a grant that arrives while the arbiter still reports busy. In that case the strobes must stay high.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,   // power-up delay
    ST_IDLE,
    ST_CSR,    // CAS low ahead of RAS
    ST_HOLD,   // RAS low, CAS still low
    ST_RASL,   // RAS low, CAS released
    ST_PRE,    // RAS precharge
    ST_SELF,   // self-refresh residency
    ST_SXIT    // long precharge after self-refresh
  } drs_state_e;

  // nanoseconds to clocks, rounded up, never below one clock
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned period_ps);
    longint unsigned t;
    t = (longint'(ns) * 1000 + longint'(period_ps) - 1) / longint'(period_ps);
    if (t == 0) t = 1;
    return int'(t);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_interval_tick.sv
module drs_interval_tick #(
  parameter int unsigned REFI_CYC = 1950,
  localparam int unsigned CW = $clog2(REFI_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == CW'(REFI_CYC - 1));

  always_comb begin
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: interval expiries never come back to back
  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && REFI_CYC > 1) |=> !tick_o);

endmodule

// File: rtl/drs_owed_counter.sv
module drs_owed_counter #(
  parameter int unsigned OWED_MAX = 4,
  localparam int unsigned OW = $clog2(OWED_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic nz_o,
  output logic full_o
);

  logic [OW-1:0] owed_q, owed_d;
  logic          upd;

  assign nz_o   = (owed_q != '0);
  assign full_o = (owed_q == OW'(OWED_MAX));

  always_comb begin
    owed_d = owed_q;
    upd    = 1'b0;
    if (clr_i) begin
      owed_d = '0;
      upd    = 1'b1;
    end else if (inc_i && !dec_i && !full_o) begin
      owed_d = owed_q + 1'b1;
      upd    = 1'b1;
    end else if (dec_i && !inc_i && nz_o) begin
      owed_d = owed_q - 1'b1;
      upd    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   owed_q <= '0;
    else if (upd) owed_q <= owed_d;
  end

  // R6: the debt never exceeds its ceiling
  p_owed_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(OWED_MAX));
  // R11: simultaneous expiry and retirement cancel out
  p_tick_and_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i && !clr_i) |=> (owed_q == $past(owed_q)));
  // R10: self-refresh entry wipes the debt
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (owed_q == '0));

endmodule

// File: rtl/drs_cycle_fsm.sv
module drs_cycle_fsm
  import drs_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 25000,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned CSR_CYC     = 2,
  parameter int unsigned CHR_CYC     = 2,
  parameter int unsigned RASL_CYC    = 6,
  parameter int unsigned RP_CYC      = 5,
  parameter int unsigned SELF_CYC    = 12500,
  parameter int unsigned RPS_CYC     = 14,
  parameter int unsigned TMR_W       = 15,
  localparam int unsigned INIT_W     = $clog2(INIT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt_i,
  input  logic busy_i,
  input  logic lp_i,
  input  logic owed_nz_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic idle_o,
  output logic init_done_o,
  output logic self_act_o,
  output logic take_o,
  output logic enter_self_o,
  output logic done_o
);

  drs_state_e        st_q, st_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [INIT_W-1:0] icnt_q, icnt_d;
  logic              icnt_en;
  logic              init_q, init_d;
  logic              self_q, self_d;
  logic              done_q, done_d;
  logic              ras_q, ras_d;
  logic              cas_q, cas_d;
  logic              tmr_zero, accept;

  assign tmr_zero = (tmr_q == '0);
  assign accept   = (st_q == ST_IDLE) && init_q && gnt_i && !busy_i && (owed_nz_i || lp_i);

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_zero ? tmr_q : tmr_q - 1'b1;
    icnt_d  = icnt_q;
    icnt_en = 1'b0;
    init_d  = init_q;
    self_d  = self_q;
    done_d  = 1'b0;
    unique case (st_q)
      ST_WAIT: if (tmr_zero) begin
        st_d  = ST_CSR;
        tmr_d = TMR_W'(CSR_CYC - 1);
      end
      ST_IDLE: if (accept) begin
        st_d   = ST_CSR;
        tmr_d  = TMR_W'(CSR_CYC - 1);
        self_d = lp_i;
      end
      ST_CSR: if (tmr_zero) begin
        if (self_q) begin
          st_d  = ST_SELF;
          tmr_d = TMR_W'(SELF_CYC - 1);
        end else begin
          st_d  = ST_HOLD;
          tmr_d = TMR_W'(CHR_CYC - 1);
        end
      end
      ST_HOLD: if (tmr_zero) begin
        st_d  = ST_RASL;
        tmr_d = TMR_W'(RASL_CYC - 1);
      end
      ST_RASL: if (tmr_zero) begin
        st_d  = ST_PRE;
        tmr_d = TMR_W'(RP_CYC - 1);
      end
      ST_PRE: if (tmr_zero) begin
        if (!init_q) begin
          icnt_en = 1'b1;
          icnt_d  = icnt_q + 1'b1;
          if (icnt_q == INIT_W'(INIT_CYCLES - 1)) begin
            st_d   = ST_IDLE;
            init_d = 1'b1;
          end else begin
            st_d  = ST_CSR;
            tmr_d = TMR_W'(CSR_CYC - 1);
          end
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_SELF: if (tmr_zero && !lp_i) begin
        st_d  = ST_SXIT;
        tmr_d = TMR_W'(RPS_CYC - 1);
      end
      ST_SXIT: if (tmr_zero) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        self_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
    ras_d = !((st_d == ST_HOLD) || (st_d == ST_RASL) || (st_d == ST_SELF));
    cas_d = !((st_d == ST_CSR) || (st_d == ST_HOLD) || (st_d == ST_SELF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAIT;
      tmr_q  <= TMR_W'(STARTUP_CYC - 1);
      icnt_q <= '0;
      init_q <= 1'b0;
      self_q <= 1'b0;
      done_q <= 1'b0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      init_q <= init_d;
      self_q <= self_d;
      done_q <= done_d;
      ras_q  <= ras_d;
      cas_q  <= cas_d;
      if (icnt_en) icnt_q <= icnt_d;
    end
  end

  assign ras_n_o      = ras_q;
  assign cas_n_o      = cas_q;
  assign idle_o       = (st_q == ST_IDLE);
  assign init_done_o  = init_q;
  assign self_act_o   = self_q;
  assign done_o       = done_q;
  assign take_o       = accept && !lp_i;
  assign enter_self_o = accept && lp_i;

  // R1: quiet strobes during the power-up wait
  p_quiet_startup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (ras_q && cas_q && !init_q));
  // R3: CAS is already low in the clock before RAS falls
  p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_q) |-> (!cas_q && $past(!cas_q)));
  // R5: a rising RAS is followed by at least one more high clock
  p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_q) && RP_CYC > 1 && RPS_CYC > 1) |=> ras_q);
  // R7: no strobe moves when the arbiter owns RAS
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && busy_i) |=> (ras_q && cas_q));
  // R8: completion is a single-clock pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: residency persists while low power is requested
  p_self_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SELF) && lp_i) |=> (!ras_q && !cas_q));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned STARTUP_NS    = 200000,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned REFI_NS       = 15600,
  parameter int unsigned CSR_NS        = 10,
  parameter int unsigned CHR_NS        = 15,
  parameter int unsigned RAS_NS        = 60,
  parameter int unsigned RP_NS         = 40,
  parameter int unsigned SELF_NS       = 100000,
  parameter int unsigned RPS_NS        = 110,
  parameter int unsigned OWED_MAX      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_busy_i,
  input  logic rfsh_gnt_i,
  input  logic lp_req_i,
  output logic ras_n_o,
  output logic ucas_n_o,
  output logic lcas_n_o,
  output logic rfsh_req_o,
  output logic rfsh_urgent_o,
  output logic rfsh_done_o,
  output logic init_done_o
);

  localparam int unsigned STARTUP_CYC = ns2cyc(STARTUP_NS, CLK_PERIOD_PS);
  localparam int unsigned REFI_CYC    = ns2cyc(REFI_NS, CLK_PERIOD_PS);
  localparam int unsigned CSR_CYC     = ns2cyc(CSR_NS, CLK_PERIOD_PS);
  localparam int unsigned CHR_CYC     = ns2cyc(CHR_NS, CLK_PERIOD_PS);
  localparam int unsigned RAS_CYC     = umax(ns2cyc(RAS_NS, CLK_PERIOD_PS), CHR_CYC + 1);
  localparam int unsigned RASL_CYC    = RAS_CYC - CHR_CYC;
  localparam int unsigned RP_CYC      = ns2cyc(RP_NS, CLK_PERIOD_PS);
  localparam int unsigned SELF_CYC    = ns2cyc(SELF_NS, CLK_PERIOD_PS);
  localparam int unsigned RPS_CYC     = ns2cyc(RPS_NS, CLK_PERIOD_PS);
  localparam int unsigned TMR_MAX     = umax(umax(STARTUP_CYC, SELF_CYC),
                                             umax(umax(RPS_CYC, RP_CYC), umax(RASL_CYC, umax(CSR_CYC, CHR_CYC))));
  localparam int unsigned TMR_W       = $clog2(TMR_MAX + 1);

  logic tick, owed_nz, owed_full;
  logic idle, init_done, self_act, take, enter_self, done;
  logic cas_n;

  drs_interval_tick #(.REFI_CYC(REFI_CYC)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (init_done && !self_act),
    .tick_o (tick)
  );

  drs_owed_counter #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (tick),
    .dec_i  (take),
    .clr_i  (enter_self),
    .nz_o   (owed_nz),
    .full_o (owed_full)
  );

  drs_cycle_fsm #(
    .STARTUP_CYC (STARTUP_CYC),
    .INIT_CYCLES (INIT_CYCLES),
    .CSR_CYC     (CSR_CYC),
    .CHR_CYC     (CHR_CYC),
    .RASL_CYC    (RASL_CYC),
    .RP_CYC      (RP_CYC),
    .SELF_CYC    (SELF_CYC),
    .RPS_CYC     (RPS_CYC),
    .TMR_W       (TMR_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .gnt_i        (rfsh_gnt_i),
    .busy_i       (acc_busy_i),
    .lp_i         (lp_req_i),
    .owed_nz_i    (owed_nz),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n),
    .idle_o       (idle),
    .init_done_o  (init_done),
    .self_act_o   (self_act),
    .take_o       (take),
    .enter_self_o (enter_self),
    .done_o       (done)
  );

  assign ucas_n_o      = cas_n;
  assign lcas_n_o      = cas_n;
  assign rfsh_req_o    = init_done && idle && (owed_nz || lp_req_i);
  assign rfsh_urgent_o = owed_full;
  assign rfsh_done_o   = done;
  assign init_done_o   = init_done;

  // R6: no request can be raised before initialization completes
  p_req_after_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req_o |-> init_done_o);

endmodule

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;

  // clock counts for the overrides below, worked out by hand at 8 ns
  localparam int C_CSR = 2, C_HLD = 2, C_RAS = 8, C_LOW = 6, C_PRE = 5;
  localparam int C_START = 100, C_REFI = 300, C_SELF = 200, C_RPS = 14;
  localparam int N_INIT = 8, N_MAX = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic busy, gnt, lp;
  logic ras_n, ucas_n, lcas_n, req, urgent, done, initd;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .CLK_PERIOD_PS(8000), .STARTUP_NS(800), .INIT_CYCLES(N_INIT), .REFI_NS(2400),
    .CSR_NS(10), .CHR_NS(15), .RAS_NS(60), .RP_NS(40), .SELF_NS(1600), .RPS_NS(110),
    .OWED_MAX(N_MAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_busy_i(busy), .rfsh_gnt_i(gnt), .lp_req_i(lp),
    .ras_n_o(ras_n), .ucas_n_o(ucas_n), .lcas_n_o(lcas_n), .rfsh_req_o(req),
    .rfsh_urgent_o(urgent), .rfsh_done_o(done), .init_done_o(initd)
  );

  int    vectors = 0, errors = 0;
  string tag = "R1";
  bit    model_on = 0;
  int    cyc = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d cycle=%0d", rq, what, act, exp, cyc);
    end
  endtask

  // inputs as the DUT samples them
  logic cap_busy, cap_gnt, cap_lp;
  always @(posedge clk) begin
    cap_busy <= busy;
    cap_gnt  <= gnt;
    cap_lp   <= lp;
  end

  // behavioural model: future strobe pattern {ras,cas,done} held in a queue
  logic [2:0] exp_q[$];
  int  m_start, m_cnt, m_owed, m_selfcnt;
  bit  m_init, m_initpend, m_selfpend, m_inself, m_selfact;

  task automatic push_n(input logic [2:0] v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  // edge monitor state, independent of the model
  int casl_pre, ras_lo, ras_hi, cas_hold, ras_falls, done_cnt;
  logic p_ras, p_cas;

  always @(negedge clk) begin
    if (model_on) begin
      logic [2:0] ex;
      bit tick, idle_b, acc, got, exp_idle;
      cyc++;
      tick   = m_init && !m_selfact && (m_cnt == C_REFI - 1);
      idle_b = (m_start == 0) && (exp_q.size() == 0) && !m_inself && !m_selfpend;
      acc    = idle_b && m_init && cap_gnt && !cap_busy && (m_owed > 0 || cap_lp);
      m_cnt  = (!(m_init && !m_selfact) || tick) ? 0 : m_cnt + 1;
      if (acc && cap_lp) m_owed = 0;
      else if (tick && !acc) m_owed = (m_owed < N_MAX) ? m_owed + 1 : m_owed;
      else if (acc && !tick) m_owed = m_owed - 1;
      if (acc) begin
        push_n(3'b100, C_CSR);
        if (cap_lp) begin m_selfpend = 1; m_selfact = 1; end
        else begin
          push_n(3'b000, C_HLD); push_n(3'b010, C_LOW); push_n(3'b110, C_PRE); push_n(3'b111, 1);
        end
      end
      if (m_start > 0) begin
        m_start--;
        if (m_start == 0) begin
          for (int k = 0; k < N_INIT; k++) begin
            push_n(3'b100, C_CSR); push_n(3'b000, C_HLD); push_n(3'b010, C_LOW); push_n(3'b110, C_PRE);
          end
          m_initpend = 1;
        end
      end else if (m_initpend && exp_q.size() == 0) begin
        m_init = 1; m_initpend = 0;
      end
      if (exp_q.size() == 0 && m_selfpend) begin
        m_selfpend = 0; m_inself = 1; m_selfcnt = 0;
      end
      got = 0; ex = 3'b110; exp_idle = 1;
      if (m_inself) begin
        if (m_selfcnt >= C_SELF && !cap_lp) begin
          push_n(3'b110, C_RPS); push_n(3'b111, 1); m_inself = 0;
        end else begin
          m_selfcnt++; ex = 3'b000; got = 1; exp_idle = 0;
        end
      end
      if (!got && exp_q.size() != 0) begin
        ex = exp_q.pop_front();
        exp_idle = ex[0];
        if (ex[0]) m_selfact = 0;
      end
      // clock-by-clock comparison
      vectors++;
      if (ras_n !== ex[2]) begin errors++; $display("FAIL %s ras_n act=%b exp=%b cycle=%0d", tag, ras_n, ex[2], cyc); end
      if (ucas_n !== ex[1] || lcas_n !== ex[1]) begin errors++;
        $display("FAIL %s cas_n act=%b%b exp=%b cycle=%0d", tag, ucas_n, lcas_n, ex[1], cyc); end
      if (done !== ex[0]) begin errors++; $display("FAIL %s(R8) done act=%b exp=%b cycle=%0d", tag, done, ex[0], cyc); end
      if (initd !== m_init) begin errors++; $display("FAIL %s(R2) init_done act=%b exp=%b cycle=%0d", tag, initd, m_init, cyc); end
      if (req !== (m_init && exp_idle && (m_owed > 0 || cap_lp))) begin errors++;
        $display("FAIL %s(R6) req act=%b exp=%b cycle=%0d", tag, req, (m_init && exp_idle && (m_owed > 0 || cap_lp)), cyc); end
      if (urgent !== (m_owed == N_MAX)) begin errors++;
        $display("FAIL %s(R6) urgent act=%b exp=%b cycle=%0d", tag, urgent, (m_owed == N_MAX), cyc); end
      // edge spacing monitor (R3, R4, R5, R9)
      if (p_ras && !ras_n) begin
        ras_falls++;
        chk(casl_pre == C_CSR, "R3", "cas lead clocks", casl_pre, C_CSR);
        chk(ras_hi >= C_PRE, "R5", "ras high clocks", ras_hi, C_PRE);
      end
      if (!p_ras && ras_n) begin
        if (ras_lo >= C_SELF) chk(1, "R9", "self residency", ras_lo, C_SELF);
        else chk(ras_lo == C_RAS, "R4", "ras low clocks", ras_lo, C_RAS);
      end
      if (!p_cas && ucas_n && !ras_n) chk(cas_hold == C_HLD, "R4", "cas hold clocks", cas_hold, C_HLD);
      casl_pre = (!ucas_n && ras_n) ? casl_pre + 1 : 0;
      ras_lo   = !ras_n ? ras_lo + 1 : 0;
      ras_hi   = ras_n ? ras_hi + 1 : 0;
      cas_hold = (!ucas_n && !ras_n) ? cas_hold + 1 : 0;
      if (done) done_cnt++;
      p_ras = ras_n; p_cas = ucas_n;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", tag);
    summary();
  end

  task automatic step_n(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_req();
    while (!req) step_n(1);
  endtask

  task automatic grant_once();
    wait_req();
    gnt = 1'b1; step_n(1); gnt = 1'b0;
  endtask

  initial begin
    int t0, d0;
    rst_n = 1'b0; busy = 0; gnt = 0; lp = 0;
    m_start = C_START; m_cnt = 0; m_owed = 0; m_selfcnt = 0;
    m_init = 0; m_initpend = 0; m_selfpend = 0; m_inself = 0; m_selfact = 0;
    casl_pre = 0; ras_lo = 0; ras_hi = 0; cas_hold = 0; ras_falls = 0; done_cnt = 0;
    p_ras = 1; p_cas = 1;
    step_n(3);
    // R1: reset state
    chk(ras_n && ucas_n && lcas_n, "R1", "strobes in reset", {ras_n, ucas_n, lcas_n}, 7);
    chk(!initd && !req, "R1", "init/req in reset", {initd, req}, 0);
    rst_n = 1'b1; model_on = 1;
    step_n(C_START - 5);
    chk(ras_n && ucas_n, "R1", "strobes during start-up", {ras_n, ucas_n}, 3);
    tag = "R2";
    while (!initd) step_n(1);
    chk(ras_falls == N_INIT, "R2", "init cycles", ras_falls, N_INIT);
    t0 = cyc;
    tag = "R6";
    wait_req();
    chk(cyc - t0 == C_REFI, "R6", "first request delay", cyc - t0, C_REFI);
    while (!urgent) step_n(1);
    step_n(C_REFI);
    chk(urgent, "R6", "saturated urgent", urgent, 1);
    tag = "R7";
    busy = 1; gnt = 1; step_n(6); gnt = 0;
    chk(ras_n && ucas_n, "R7", "strobes while busy", {ras_n, ucas_n}, 3);
    busy = 0;
    tag = "R8";
    d0 = done_cnt;
    for (int i = 0; i < N_MAX; i++) begin grant_once(); step_n(C_CSR + C_RAS + C_PRE + 1); end
    chk(done_cnt == d0 + N_MAX, "R8", "done pulses", done_cnt - d0, N_MAX);
    tag = "R11";
    wait_req();
    while (m_cnt != C_REFI - 1) step_n(1);
    gnt = 1; step_n(1); gnt = 0;
    step_n(C_CSR + C_RAS + C_PRE + 2);
    chk(req, "R11", "debt kept after overlap", req, 1);
    tag = "R9";
    lp = 1; grant_once(); step_n(250);
    chk(!ras_n && !ucas_n, "R9", "held in self-refresh", {ras_n, ucas_n}, 0);
    tag = "R10";
    lp = 0; d0 = done_cnt;
    step_n(C_RPS + 4);
    chk(done_cnt == d0 + 1, "R10", "exit done pulse", done_cnt - d0, 1);
    chk(!req, "R10", "debt cleared by entry", req, 0);
    tag = "R9";
    lp = 1; grant_once(); step_n(20); lp = 0;
    step_n(C_SELF + C_RPS + 10);
    chk(ras_n && ucas_n, "R10", "strobes after exit", {ras_n, ucas_n}, 3);
    step_n(40);
    summary();
  end

endmodule